// File: doc/BRIEF.md
# Opcode-Fetch Wait-State Inserter

This block drives the active-low wait input of an 8-bit processor so that each opcode-fetch bus cycle is stretched by exactly one wait state. The fetch cycle reads its instruction byte in its first two clock states and uses the last two for refresh. The processor samples the wait line on the falling clock edge inside the second state. The block therefore recognises a fetch on the rising edge that opens that state, and it raises the wait request from that edge. Slow program memory gets a full extra clock period to deliver the byte.

The decision uses only the opcode-fetch strobe, the memory-request strobe and two mode inputs. The address bus may still be settling when the decision is taken, so the block never looks at it. Plain memory reads and writes, refresh, I/O and interrupt-acknowledge cycles pass without extra states. A global enable turns the feature off. A ROM-only mode limits the stretch to the time when the boot ROM is mapped in, since fetches then come from the slow ROM.

Top module: `fetch_stretch`

## Requirements
- R1: If opfetch_n and memreq_n are both low at a rising edge, while the block is idle and the policy allows a stretch, hold_n is low for the whole clock period that follows that edge.
- R2: hold_n returns high at the next rising edge after it went low, so each opcode fetch gets exactly one wait state.
- R3: A memory cycle with opfetch_n high never drives hold_n low.
- R4: opfetch_n low with memreq_n high (interrupt acknowledge) never drives hold_n low.
- R5: If opfetch_n stays low for any number of cycles, at most one wait state is inserted. A new one needs opfetch_n to be seen high at a rising edge first.
- R6: With stretch_en low at the deciding edge, no wait state is inserted.
- R7: With rom_only_mode high, a wait state is inserted only if boot_rom_on is high at the deciding edge. With rom_only_mode low, boot_rom_on has no effect.
- R8: While rst_n is low, hold_n is high at once, even in the middle of a stretched fetch.
- R9: hold_n is high in every clock period in which opfetch_n is high, which includes the refresh states of a fetch.
- R10: Fetch cycles that follow each other with no gap each receive their own single wait state.
- R11: After rst_n is released, hold_n stays high until the next qualifying fetch, and that fetch is stretched normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low processor reset, asynchronous |
| opfetch_n | input | 1 | Active-low opcode-fetch strobe from the processor |
| memreq_n | input | 1 | Active-low memory-request strobe from the processor |
| boot_rom_on | input | 1 | High while the boot ROM is mapped into the address space |
| rom_only_mode | input | 1 | High limits stretching to times when boot_rom_on is high |
| stretch_en | input | 1 | High enables wait-state insertion |
| hold_n | output | 1 | Active-low wait request to the processor |

## Verification
The bench drives the opcode-fetch strobe 1 ns after the rising edge and the memory strobe 1 ns after the falling edge, the way the processor moves them. A fetch is therefore recognised at the rising edge that opens its second state. One register lies between that edge and hold_n, so the low level is visible in the same period. The bench samples every period 2 ns after its rising edge, before the falling edge at which the processor would sample. The release is due one period later, and the bench checks it in the inserted state. Reset and a high opfetch_n gate the output directly, so their effect is checked within the period in which they change.

// File: rtl/fs_pkg.sv
package fs_pkg;

    typedef enum logic [1:0] {
        BUS_IDLE  = 2'd0,   // no strobe active
        BUS_FETCH = 2'd1,   // opcode fetch with memory request
        BUS_ACK   = 2'd2,   // opcode strobe without memory request
        BUS_MEM   = 2'd3    // memory request only (read, write, refresh)
    } fs_bus_e;

    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_HOLD = 2'd1,
        FS_DONE = 2'd2
    } fs_state_e;

endpackage

// File: rtl/fs_cycle_detect.sv
module fs_cycle_detect
    import fs_pkg::*;
(
    input  logic    opfetch_n,
    input  logic    memreq_n,
    output fs_bus_e bus_cls
);

    always_comb begin
        unique case ({opfetch_n, memreq_n})
            2'b00:   bus_cls = BUS_FETCH;
            2'b01:   bus_cls = BUS_ACK;
            2'b10:   bus_cls = BUS_MEM;
            default: bus_cls = BUS_IDLE;
        endcase
    end

endmodule

// File: rtl/fs_policy.sv
module fs_policy #(
    parameter bit HAS_ROM_GATE = 1'b1
) (
    input  logic stretch_en,
    input  logic rom_only_mode,
    input  logic boot_rom_on,
    output logic allow
);

    generate
        if (HAS_ROM_GATE) begin : g_gate
            always_comb allow = stretch_en & (~rom_only_mode | boot_rom_on);
        end else begin : g_plain
            logic unused_mode;
            always_comb unused_mode = rom_only_mode ^ boot_rom_on;
            always_comb allow = stretch_en;
        end
    endgenerate

endmodule

// File: rtl/fs_wait_fsm.sv
module fs_wait_fsm
    import fs_pkg::*;
#(
    parameter int WAIT_CYCLES = 1
) (
    input  logic    clk,
    input  logic    rst_n,
    input  fs_bus_e bus_cls,
    input  logic    allow,
    output logic    wait_q_o
);

    localparam int CNT_W = $clog2(WAIT_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WAIT_CYCLES);

    typedef struct packed {
        fs_state_e        state;
        logic [CNT_W-1:0] cnt;
        logic             wait_on;
    } fsm_regs_t;

    fsm_regs_t q, d;
    logic      strobe_off;

    always_comb strobe_off = (bus_cls == BUS_IDLE) || (bus_cls == BUS_MEM);

    always_comb begin
        d = q;
        unique case (q.state)
            FS_IDLE: begin
                d.wait_on = 1'b0;
                if (bus_cls == BUS_FETCH) begin
                    if (allow) begin
                        d.state   = FS_HOLD;
                        d.cnt     = CNT_W'(1);
                        d.wait_on = 1'b1;
                    end else begin
                        d.state = FS_DONE;
                    end
                end
            end
            FS_HOLD: begin
                if (strobe_off) begin
                    d.state   = FS_IDLE;
                    d.wait_on = 1'b0;
                end else if (q.cnt == CNT_LAST) begin
                    d.state   = FS_DONE;
                    d.wait_on = 1'b0;
                end else begin
                    d.cnt     = q.cnt + CNT_W'(1);
                    d.wait_on = 1'b1;
                end
            end
            FS_DONE: begin
                d.wait_on = 1'b0;
                if (strobe_off) d.state = FS_IDLE;
            end
            default: begin
                d.state   = FS_IDLE;
                d.wait_on = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: FS_IDLE, cnt: '0, wait_on: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign wait_q_o = q.wait_on;

    AST_FETCH_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == FS_IDLE && bus_cls == BUS_FETCH && allow) |=> wait_q_o); // R1

    generate
        if (WAIT_CYCLES == 1) begin : g_one
            AST_SINGLE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
                wait_q_o |=> !wait_q_o); // R2
        end
    endgenerate

    AST_NO_MEM_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_off |=> !wait_q_o); // R3

    AST_NO_ACK_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cls == BUS_ACK && !wait_q_o) |=> !wait_q_o); // R4

    AST_ONCE_PER_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == FS_DONE && !strobe_off) |=> !wait_q_o); // R5

    AST_POLICY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (!allow && !wait_q_o) |=> !wait_q_o); // R6

endmodule

// File: rtl/fetch_stretch.sv
module fetch_stretch
    import fs_pkg::*;
#(
    parameter int WAIT_CYCLES  = 1,
    parameter bit HAS_ROM_GATE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic opfetch_n,
    input  logic memreq_n,
    input  logic boot_rom_on,
    input  logic rom_only_mode,
    input  logic stretch_en,
    output logic hold_n
);

    fs_bus_e bus_cls;
    logic    allow;
    logic    wait_q;

    fs_cycle_detect u_detect (
        .opfetch_n (opfetch_n),
        .memreq_n  (memreq_n),
        .bus_cls   (bus_cls)
    );

    fs_policy #(
        .HAS_ROM_GATE (HAS_ROM_GATE)
    ) u_policy (
        .stretch_en    (stretch_en),
        .rom_only_mode (rom_only_mode),
        .boot_rom_on   (boot_rom_on),
        .allow         (allow)
    );

    fs_wait_fsm #(
        .WAIT_CYCLES (WAIT_CYCLES)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_cls  (bus_cls),
        .allow    (allow),
        .wait_q_o (wait_q)
    );

    // Reset and an inactive opcode strobe release the line without waiting for an edge.
    assign hold_n = ~(wait_q & rst_n & ~opfetch_n);

    AST_ROM_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_only_mode && !boot_rom_on && hold_n) |=> hold_n); // R7

    AST_REFRESH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (opfetch_n && !memreq_n) |=> hold_n); // R9

endmodule

// File: tb/sim_fetch_stretch.sv
`timescale 1ns/1ps
module sim_fetch_stretch;

    logic clk = 1'b0;
    logic rst_n, opfetch_n, memreq_n, boot_rom_on, rom_only_mode, stretch_en;
    logic hold_n;

    always #2.5 clk = ~clk;

    fetch_stretch u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .opfetch_n     (opfetch_n),
        .memreq_n      (memreq_n),
        .boot_rom_on   (boot_rom_on),
        .rom_only_mode (rom_only_mode),
        .stretch_en    (stretch_en),
        .hold_n        (hold_n)
    );

    typedef struct {
        bit    exp;
        string tag;
    } item_t;

    item_t sb[$];
    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    task automatic chk(input logic act, input bit exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: hold_n=%b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // Monitor: one comparison per clock period, 2 ns after the rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                chk(hold_n, it.exp, it.tag);
            end
        end
    end

    // One bus state: opcode strobe and early memory strobe move after the rising
    // edge, the late memory strobe moves after the falling edge.
    task automatic tstate(input bit f, input bit mr, input bit mf, input bit exp, input string tag);
        item_t it;
        @(posedge clk);
        it.exp = exp;
        it.tag = tag;
        sb.push_back(it);
        #1;
        opfetch_n = f;
        memreq_n  = mr;
        @(negedge clk);
        #1;
        memreq_n  = mf;
    endtask

    task automatic fetch(input bit stretched, input string tag);
        tstate(1'b0, 1'b1, 1'b0, 1'b1, tag);          // first state
        tstate(1'b0, 1'b0, 1'b0, !stretched, tag);    // second state, decision
        if (stretched)
            tstate(1'b0, 1'b0, 1'b0, 1'b1, "R2");     // inserted state, released
        tstate(1'b1, 1'b1, 1'b0, 1'b1, "R9");         // refresh, first half
        tstate(1'b1, 1'b0, 1'b1, 1'b1, "R9");         // refresh, second half
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; opfetch_n = 1'b1; memreq_n = 1'b1;
        boot_rom_on = 1'b0; rom_only_mode = 1'b0; stretch_en = 1'b1;
        repeat (2) @(posedge clk);
        #2 chk(hold_n, 1'b1, "R11 reset state");
        // Strobes active while in reset: no wait (R8)
        tstate(1'b0, 1'b1, 1'b0, 1'b1, "R8");
        tstate(1'b0, 1'b0, 1'b0, 1'b1, "R8");
        tstate(1'b1, 1'b1, 1'b1, 1'b1, "R8");
        @(posedge clk); #1 rst_n = 1'b1;

        fetch(1'b1, "R1");
        fetch(1'b1, "R10");
        fetch(1'b1, "R10");

        // Plain memory read then write (R3)
        tstate(1'b1, 1'b1, 1'b0, 1'b1, "R3");
        tstate(1'b1, 1'b0, 1'b0, 1'b1, "R3");
        tstate(1'b1, 1'b0, 1'b1, 1'b1, "R3");
        tstate(1'b1, 1'b1, 1'b0, 1'b1, "R3");
        tstate(1'b1, 1'b0, 1'b0, 1'b1, "R3");
        tstate(1'b1, 1'b0, 1'b1, 1'b1, "R3");

        // Interrupt acknowledge: opcode strobe without memory request (R4)
        for (int i = 0; i < 4; i++) tstate(1'b0, 1'b1, 1'b1, 1'b1, "R4");
        tstate(1'b1, 1'b1, 1'b1, 1'b1, "R4");
        fetch(1'b1, "R4");

        // Opcode strobe held low for many states: one wait only (R5)
        tstate(1'b0, 1'b1, 1'b0, 1'b1, "R5");
        tstate(1'b0, 1'b0, 1'b0, 1'b0, "R5");
        tstate(1'b0, 1'b0, 1'b0, 1'b1, "R2");
        for (int i = 0; i < 4; i++) tstate(1'b0, 1'b0, 1'b0, 1'b1, "R5");
        tstate(1'b1, 1'b1, 1'b1, 1'b1, "R5");
        fetch(1'b1, "R5");

        // Global enable off (R6)
        stretch_en = 1'b0;
        fetch(1'b0, "R6");
        fetch(1'b0, "R6");
        stretch_en = 1'b1;
        fetch(1'b1, "R6");

        // ROM-only mode (R7)
        rom_only_mode = 1'b1; boot_rom_on = 1'b0;
        fetch(1'b0, "R7");
        boot_rom_on = 1'b1;
        fetch(1'b1, "R7");
        rom_only_mode = 1'b0; boot_rom_on = 1'b0;
        fetch(1'b1, "R7");
        boot_rom_on = 1'b1;
        fetch(1'b1, "R7");
        boot_rom_on = 1'b0;

        // Reset during a stretched fetch (R8), then recovery (R11)
        tstate(1'b0, 1'b1, 1'b0, 1'b1, "R8");
        begin
            item_t it;
            @(posedge clk);
            it.exp = 1'b1;
            it.tag = "R8";
            sb.push_back(it);
            #1 rst_n = 1'b0;
        end
        tstate(1'b0, 1'b0, 1'b0, 1'b1, "R8");
        tstate(1'b1, 1'b1, 1'b1, 1'b1, "R8");
        @(posedge clk); #1 rst_n = 1'b1;
        tstate(1'b1, 1'b1, 1'b1, 1'b1, "R11");
        fetch(1'b1, "R11");

        repeat (3) @(posedge clk);
        #3;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule